// File: doc/BRIEF.md
# Programmable Delayed Pulse Generator

This block drives one output channel with a train of pulses timed entirely in clock cycles. Three cycle counts arrive as inputs: a start delay, a high-time width and a repetition period. When the channel enable goes high, the block waits out the delay and then produces pulses of the programmed width. A new pulse starts every period for as long as the channel stays enabled. If the period is not larger than the width, the block instead emits exactly one pulse and then holds the output low until the channel is disabled and enabled again.

Along with the pulse output, the block gives a one-cycle strobe that marks the first high cycle of each pulse. It also gives an LED drive that is stretched to a programmable number of cycles so that short pulses can still be seen. The logic that writes the cycle counts, decodes registers or converts a frequency into a period count is outside this block.

Top module: `dly_pulse_gen`

## Requirements
- R1: After synchronous active-low reset, `pulse_o`, `start_o` and `led_o` are all 0.
- R2: The enable is sampled on a rising clock edge, in the idle state. With a delay count of 0, `pulse_o` is 1 in the cycle right after that edge. With a delay count of D, the first high cycle comes D cycles later.
- R3: Each pulse keeps `pulse_o` high for exactly W consecutive cycles, where W is the width count and W is at least 1.
- R4: When the period count P is greater than W, a new pulse starts every P cycles for as long as the enable is held.
- R5: When P is less than or equal to W, exactly one pulse is produced after enable. The output then stays low until the enable is cleared and set again.
- R6: The delay count is taken only at the enabling edge. Changes to it while the channel is enabled have no effect on the running train.
- R7: The period and width counts are latched at each pulse start. A change made while the channel runs takes effect from the next period boundary.
- R8: While the enable is 0, `pulse_o` and `start_o` are 0 in the same cycle, without waiting for a clock edge, and the block returns to idle. A later enable starts again with the delay.
- R9: `start_o` is 1 for exactly one cycle, the first high cycle of each pulse. A rising edge on `pulse_o` always coincides with `start_o`.
- R10: `led_o` goes high in the cycle after each `start_o` and stays high for L cycles, where L is `led_len_i` and L is at least 1. A start that comes while the LED is still lit reloads the count to L.
- R11: With P = 1250 and W = 150 on a 125 MHz clock, the output is a 100 kHz train: 150 cycles high, then 1100 cycles low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Channel enable |
| delay_cnt_i | input | CNT_W | Start delay in cycles, taken at enable |
| width_cnt_i | input | CNT_W | Pulse high time in cycles |
| period_cnt_i | input | CNT_W | Repetition period in cycles |
| led_len_i | input | LED_W | LED stretch length in cycles |
| pulse_o | output | 1 | Pulse output |
| start_o | output | 1 | One-cycle strobe on the first high cycle of each pulse |
| led_o | output | 1 | Stretched LED drive |

## Verification
The assertions check the cycle-local rules on every cycle. The output is low whenever the channel is off. The strobe lasts one cycle, lies inside a pulse and marks every rising edge of the output. The LED lights in the cycle after each strobe. Exact cycle counts need the bench's scenarios: the delay, the width, the period, the single-pulse outcome, and the latching of a new period or a changed delay. The bench compares whole traces of the output, the strobe and the LED against expected sequences built from the requirements.

// File: rtl/dpg_pkg.sv
// Shared types for the delayed pulse generator.
// Assumes nothing beyond a synchronous design context.
package dpg_pkg;
    // Phases of the start-delay sequencer
    typedef enum logic [1:0] {
        DLY_IDLE  = 2'd0,  // channel disabled, waiting for enable
        DLY_WAIT  = 2'd1,  // counting down the start delay
        DLY_SPENT = 2'd2   // train launched, nothing more to do until disable
    } dly_state_t;
endpackage

// File: rtl/dpg_delay.sv
// Start-delay sequencer. It samples the delay count on the enabling edge and
// raises launch_o (combinational) during the cycle whose closing edge must
// start the pulse train. Assumes the enable is synchronous to clk.
module dpg_delay
    import dpg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             launch_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dly_state_t       st_q;
    logic [CNT_W-1:0] left_q;

    // Launch now: zero delay seen at enable, or last delay cycle reached
    always_comb begin
        launch_o = en_i && (((st_q == DLY_IDLE) && (delay_i == '0)) ||
                            ((st_q == DLY_WAIT) && (left_q == ONE)));
    end

    // Sequencer state and remaining-delay counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= DLY_IDLE;
            left_q <= '0;
        end else if (!en_i) begin
            st_q   <= DLY_IDLE;
        end else begin
            case (st_q)
                DLY_IDLE: begin
                    if (delay_i == '0) begin
                        st_q <= DLY_SPENT;
                    end else begin
                        st_q   <= DLY_WAIT;
                        left_q <= delay_i;
                    end
                end
                DLY_WAIT: begin
                    if (left_q == ONE) st_q <= DLY_SPENT;
                    left_q <= left_q - ONE;
                end
                default: st_q <= DLY_SPENT;
            endcase
        end
    end
endmodule

// File: rtl/dpg_train.sv
// Pulse train engine. A launch starts a pulse. It latches the period and width
// at every pulse start. If period > width it repeats; otherwise it stops after
// one pulse. Assumes width >= 1. Outputs are gated by the enable combinationally.
module dpg_train #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             launch_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o,
    output logic             start_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             run_q;
    logic [CNT_W-1:0] ph_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] wid_q;
    logic             repeat_w;

    // Repetition is chosen from the counts latched for the current pulse
    always_comb begin
        repeat_w = per_q > wid_q;
    end

    // Output decode, forced low at once when the channel is disabled
    always_comb begin
        pulse_o = en_i && run_q && (ph_q < wid_q);
        start_o = en_i && run_q && (ph_q == '0);
    end

    // Phase counter with boundary latching of period and width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            per_q <= '0;
            wid_q <= '0;
        end else if (!en_i) begin
            run_q <= 1'b0;
        end else if (launch_i) begin
            run_q <= 1'b1;
            ph_q  <= '0;
            per_q <= period_i;
            wid_q <= width_i;
        end else if (run_q) begin
            if (repeat_w) begin
                if (ph_q == per_q - ONE) begin
                    ph_q  <= '0;
                    per_q <= period_i;
                    wid_q <= width_i;
                end else begin
                    ph_q <= ph_q + ONE;
                end
            end else if (ph_q == wid_q - ONE) begin
                run_q <= 1'b0;
            end else begin
                ph_q <= ph_q + ONE;
            end
        end
    end
endmodule

// File: rtl/dpg_led.sv
// LED stretcher. Every start strobe reloads a down-counter with the stretch
// length; the LED is lit while the counter is non-zero. Assumes length >= 1.
module dpg_led #(
    parameter int LED_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LED_W-1:0] len_i,
    output logic             led_o
);
    logic [LED_W-1:0] cnt_q;

    // Reload on each strobe, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= len_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - LED_W'(1);
    end

    // Lit while the stretch count runs
    always_comb begin
        led_o = cnt_q != '0;
    end
endmodule

// File: rtl/dly_pulse_gen.sv
// Top of the single-channel delayed pulse generator: a start-delay sequencer,
// a pulse train engine and an LED stretcher. All counts are in clock cycles.
// Assumes width_cnt_i >= 1 and led_len_i >= 1.
module dly_pulse_gen #(
    parameter int CNT_W = 32,
    parameter int LED_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] delay_cnt_i,
    input  logic [CNT_W-1:0] width_cnt_i,
    input  logic [CNT_W-1:0] period_cnt_i,
    input  logic [LED_W-1:0] led_len_i,
    output logic             pulse_o,
    output logic             start_o,
    output logic             led_o
);
    logic launch_w;

    dpg_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .delay_i  (delay_cnt_i),
        .launch_o (launch_w)
    );

    dpg_train #(.CNT_W(CNT_W)) u_train (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .launch_i (launch_w),
        .period_i (period_cnt_i),
        .width_i  (width_cnt_i),
        .pulse_o  (pulse_o),
        .start_o  (start_o)
    );

    dpg_led #(.LED_W(LED_W)) u_led (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_o),
        .len_i   (led_len_i),
        .led_o   (led_o)
    );
endmodule

// File: rtl/dly_pulse_gen_chk.sv
// Checker for dly_pulse_gen, attached with bind. It observes ports only.
module dly_pulse_gen_chk #(
    parameter int LED_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic [LED_W-1:0] led_len_i,
    input logic             pulse_o,
    input logic             start_o,
    input logic             led_o
);
    // R8: a disabled channel drives nothing
    assert_low_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!pulse_o && !start_o));

    // R9: the strobe sits inside a pulse
    assert_start_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> pulse_o);

    // R9: the strobe lasts a single cycle
    assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R9: every rising output edge is marked by the strobe
    assert_rise_has_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> start_o);

    // R10: the LED lights in the cycle after a strobe
    assert_led_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && led_len_i != '0) |=> led_o);
endmodule

bind dly_pulse_gen dly_pulse_gen_chk #(.LED_W(LED_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .led_len_i (led_len_i),
    .pulse_o   (pulse_o),
    .start_o   (start_o),
    .led_o     (led_o)
);

// File: tb/dly_pulse_gen_tb_top.sv
// Directed bench for dly_pulse_gen: one task per scenario, each checking itself.
module dly_pulse_gen_tb_top;
    localparam int MAXN = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] dly = '0;
    logic [31:0] wid = 32'd1;
    logic [31:0] per = 32'd2;
    logic [23:0] led_len = 24'd1;
    logic        pulse, start, led;

    int total = 0;
    int bad = 0;

    logic pt [MAXN];
    logic st [MAXN];
    logic lt [MAXN];
    logic ep [MAXN];
    logic es [MAXN];
    logic el [MAXN];

    always #4 clk = ~clk;   // 125 MHz

    dly_pulse_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .delay_cnt_i  (dly),
        .width_cnt_i  (wid),
        .period_cnt_i (per),
        .led_len_i    (led_len),
        .pulse_o      (pulse),
        .start_o      (start),
        .led_o        (led)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Advance to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_gap();
        en = 1'b0;
        for (int k = 0; k < 40; k++) step();
    endtask

    // Compare a captured trace against its expectation, one check per signal
    task automatic compare(input string req, input int n);
        int fp, fs, fl;
        fp = -1; fs = -1; fl = -1;
        for (int i = 0; i < n; i++) begin
            if (fp < 0 && pt[i] != ep[i]) fp = i;
            if (fs < 0 && st[i] != es[i]) fs = i;
            if (fl < 0 && lt[i] != el[i]) fl = i;
        end
        chk(req, $sformatf("pulse trace first diff at %0d", fp),
            (fp < 0) ? 0 : int'(pt[fp]), (fp < 0) ? 0 : int'(ep[fp]));
        chk(req, $sformatf("start trace first diff at %0d", fs),
            (fs < 0) ? 0 : int'(st[fs]), (fs < 0) ? 0 : int'(es[fs]));
        chk(req, $sformatf("led trace first diff at %0d", fl),
            (fl < 0) ? 0 : int'(lt[fl]), (fl < 0) ? 0 : int'(el[fl]));
    endtask

    // Enable, capture n cycles, build expected traces, compare.
    // p1/chg: period input switches to p1 at sample chg (chg < 0: never).
    // dnew: delay input switches to dnew at sample 5 (dnew < 0: never).
    task automatic run_case(input string req, input int d, input int p0, input int p1,
                            input int chg, input int w, input int l, input int dnew,
                            input int n);
        int s, cur, lc;
        dly = 32'(d); per = 32'(p0); wid = 32'(w); led_len = 24'(l);
        en = 1'b1;
        for (int i = 0; i < n; i++) begin
            step();
            pt[i] = pulse; st[i] = start; lt[i] = led;
            if (i == chg) per = 32'(p1);
            if (i == 5 && dnew >= 0) dly = 32'(dnew);
        end
        for (int i = 0; i < n; i++) begin ep[i] = 1'b0; es[i] = 1'b0; end
        s = d;
        while (s < n) begin
            cur = (chg >= 0 && s - 1 >= chg) ? p1 : p0;
            es[s] = 1'b1;
            for (int k = 0; k < w; k++) if (s + k < n) ep[s + k] = 1'b1;
            if (cur <= w) break;
            s += cur;
        end
        lc = 0;
        for (int i = 0; i < n; i++) begin
            el[i] = (lc != 0);
            lc = es[i] ? l : ((lc != 0) ? lc - 1 : 0);
        end
        compare(req, n);
        idle_gap();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int k = 0; k < 4; k++) step();
        rst_n = 1'b1;
        step();
        chk("R1", "pulse after reset", int'(pulse), 0);
        chk("R1", "start after reset", int'(start), 0);
        chk("R1", "led after reset", int'(led), 0);
    endtask

    task automatic t_hundred_khz();
        int hi, fall, rise2;
        run_case("R11 R3 R4", 0, 1250, 1250, -1, 150, 4, -1, 2600);
        hi = 0; fall = -1; rise2 = -1;
        for (int i = 0; i < 1250; i++) if (pt[i]) hi++;
        for (int i = 1; i < 2600; i++) begin
            if (fall < 0 && pt[i - 1] && !pt[i]) fall = i;
            if (rise2 < 0 && !pt[i - 1] && pt[i]) rise2 = i;
        end
        chk("R11", "high cycles per period", hi, 150);
        chk("R11", "low cycles per period", rise2 - fall, 1100);
    endtask

    task automatic t_disable();
        dly = '0; per = 32'd10; wid = 32'd5; led_len = 24'd2;
        en = 1'b1;
        step(); step();
        chk("R8", "pulse high before disable", int'(pulse), 1);
        en = 1'b0;
        #1;
        chk("R8", "pulse low same cycle as disable", int'(pulse), 0);
        chk("R8", "start low while disabled", int'(start), 0);
        step();
        chk("R8", "pulse low after disable edge", int'(pulse), 0);
        en = 1'b1;
        step();
        chk("R8", "restart pulse after re-enable", int'(pulse), 1);
        chk("R8", "restart strobe after re-enable", int'(start), 1);
        idle_gap();
    endtask

    initial begin
        t_reset();
        run_case("R2 R3 R4 R10", 7, 10, 10, -1, 3, 4, -1, 60);
        run_case("R5", 3, 2, 2, -1, 5, 3, -1, 40);
        run_case("R5 equal counts", 0, 4, 4, -1, 4, 2, -1, 30);
        run_case("R6", 4, 6, 6, -1, 2, 1, 20, 50);
        run_case("R6 re-enable", 20, 6, 6, -1, 2, 1, -1, 60);
        run_case("R7", 0, 8, 5, 10, 3, 2, -1, 40);
        run_case("R10 R9 restart", 0, 10, 10, -1, 2, 15, -1, 50);
        t_disable();
        t_hundred_khz();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule